// File: doc/BRIEF.md
# Single-Cycle Hardwired 32-bit Core

This block is a small 32-bit processor core that finishes every instruction in one clock. A fixed combinational decode table turns the opcode and function field into a set of named selects. These selects steer an operand mux, an immediate extender, an ALU, a write-back mux and the next-PC logic. The core holds a program counter and a 32-entry register file with two read ports and one write port.

Instruction and data memory sit outside the core on separate ports. The instruction port carries an address out and a word back in the same cycle. The data port drives an address, write data and a write strobe, and it takes read data back combinationally. The PC, the register file and a data-memory write all take effect on the same rising edge.

Instruction layout:
- Opcode in bits 31:26, first source register in bits 25:21, second register in bits 20:16.
- Register form: destination in bits 15:11 and function code in bits 5:0.
- Immediate form: bits 15:0 hold the immediate or displacement.
- Jump form: bits 25:0 hold the offset.

Top module: `hwc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 on that edge. `dmem_we` stays low for as long as `rst` is high.
- R2: Opcode 0x00 is the register form. It writes rf3 with rf1 op rf2, where the function code selects the op: 0x20 add, 0x22 subtract (rf1-rf2), 0x24 and, 0x25 or, 0x26 xor, 0x04 shift left by rf2[4:0], 0x06 logical shift right by rf2[4:0], 0x2A signed set-less-than (1 or 0). Any other function code writes nothing.
- R3: Immediate ops write rf2. Opcodes 0x08 (add) and 0x0A (signed set-less-than) sign-extend the 16-bit immediate. Opcodes 0x09 (add), 0x0C (and), 0x0D (or) and 0x0E (xor) zero-extend it. Opcode 0x0F writes the immediate into bits 31:16 with zeros below.
- R4: Opcode 0x23 loads. `dmem_addr` is rf1 plus the sign-extended displacement, and `dmem_rdata` is written to rf2.
- R5: Opcode 0x2B stores. `dmem_addr` is rf1 plus the sign-extended displacement, `dmem_wdata` is rf2, and `dmem_we` is high in that cycle only.
- R6: Opcode 0x04 branches when rf1 is zero. If rf1 is zero, the next PC is PC+4 plus the sign-extended 16-bit offset. Otherwise it is PC+4.
- R7: Opcodes 0x02 and 0x03 jump to PC+4 plus the sign-extended 26-bit offset. Opcode 0x03 also writes PC+4 into R31.
- R8: Opcodes 0x12 and 0x13 jump to the value of rf1. Opcode 0x13 also writes PC+4 into R31. Opcode 0x12 writes no register.
- R9: R0 always reads as zero, and writes to it are dropped.
- R10: Any other opcode writes no register and no memory, and advances the PC by 4.
- R11: Every instruction other than a taken branch or a jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data-memory address (ALU result) |
| dmem_wdata | output | 32 | Store data (value of rf2) |
| dmem_we | output | 1 | Store strobe, sampled on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
A wrong register value stays hidden until a later store puts it on `dmem_wdata`, or until a register-indirect jump puts it on `imem_addr`. The bench therefore follows each group of computations with a store or jump, so a corrupted register shows within a few cycles. A wrong next-PC choice shows on `imem_addr` in the very next cycle. The bench compares the fetch address at every step of an execution trace that covers taken and untaken branches, backward jumps and both link forms. A spurious write, such as one to R0, by an unknown opcode, or by a plain register jump, shows when a later store reads back the register that could have been clobbered.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int XLEN     = 32;
  localparam int NREG     = 32;
  localparam int RIDX     = $clog2(NREG);
  localparam int OPW      = 6;
  localparam int FNW      = 6;
  localparam int IMM_S    = 16;
  localparam int IMM_L    = 26;
  localparam int LINK_REG = NREG - 1;
  localparam int PC_STEP  = 4;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL, ALU_SRL, ALU_SLT, ALU_PASSB
  } alu_op_e;
  typedef enum logic [1:0] {EXT_S16, EXT_Z16, EXT_S26, EXT_HI16} ext_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_e;
  typedef enum logic [1:0] {DST_RF2, DST_RF3, DST_LINK} dst_e;
  typedef enum logic [1:0] {PCS_SEQ, PCS_BRZ, PCS_REL, PCS_IND} pcs_e;

  typedef struct packed {
    logic    b_imm;
    ext_e    ext;
    alu_op_e alu;
    wb_e     wb;
    dst_e    dst;
    logic    reg_we;
    logic    mem_we;
    pcs_e    pcs;
  } ctrl_t;

  localparam logic [OPW-1:0] OP_REG  = 6'h00, OP_J    = 6'h02, OP_JAL  = 6'h03,
                             OP_BEQZ = 6'h04, OP_ADDI = 6'h08, OP_ADDU = 6'h09,
                             OP_SLTI = 6'h0A, OP_ANDI = 6'h0C, OP_ORI  = 6'h0D,
                             OP_XORI = 6'h0E, OP_HI   = 6'h0F, OP_JR   = 6'h12,
                             OP_JALR = 6'h13, OP_LW   = 6'h23, OP_SW   = 6'h2B;
  localparam logic [FNW-1:0] FN_SLL = 6'h04, FN_SRL = 6'h06, FN_ADD = 6'h20, FN_SUB = 6'h22,
                             FN_AND = 6'h24, FN_OR  = 6'h25, FN_XOR = 6'h26, FN_SLT = 6'h2A;

  function automatic logic [XLEN-1:0] ext_imm(input logic [IMM_L-1:0] f, input ext_e m);
    case (m)
      EXT_S16:  return {{(XLEN-IMM_S){f[IMM_S-1]}}, f[IMM_S-1:0]};
      EXT_Z16:  return {{(XLEN-IMM_S){1'b0}}, f[IMM_S-1:0]};
      EXT_S26:  return {{(XLEN-IMM_L){f[IMM_L-1]}}, f};
      default:  return {f[IMM_S-1:0], {(XLEN-IMM_S){1'b0}}};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_XOR: return a ^ b;
      ALU_SLL: return a << b[RIDX-1:0];
      ALU_SRL: return a >> b[RIDX-1:0];
      ALU_SLT: return {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      default: return b;
    endcase
  endfunction
endpackage

// File: rtl/hwc_decode.sv
module hwc_decode
  import hwc_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic [FNW-1:0] func,
  output ctrl_t          ctrl,
  output logic           known
);
  always_comb begin
    ctrl  = '{b_imm: 1'b1, ext: EXT_S16, alu: ALU_ADD, wb: WB_ALU, dst: DST_RF2,
              reg_we: 1'b0, mem_we: 1'b0, pcs: PCS_SEQ};
    known = 1'b1;
    case (opcode)
      OP_REG: begin
        ctrl.b_imm  = 1'b0;
        ctrl.dst    = DST_RF3;
        ctrl.reg_we = 1'b1;
        case (func)
          FN_ADD:  ctrl.alu = ALU_ADD;
          FN_SUB:  ctrl.alu = ALU_SUB;
          FN_AND:  ctrl.alu = ALU_AND;
          FN_OR:   ctrl.alu = ALU_OR;
          FN_XOR:  ctrl.alu = ALU_XOR;
          FN_SLL:  ctrl.alu = ALU_SLL;
          FN_SRL:  ctrl.alu = ALU_SRL;
          FN_SLT:  ctrl.alu = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: ctrl.reg_we = 1'b1;
      OP_SLTI: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SLT; end
      OP_ADDU: begin ctrl.reg_we = 1'b1; ctrl.ext = EXT_Z16; end
      OP_ANDI: begin ctrl.reg_we = 1'b1; ctrl.ext = EXT_Z16; ctrl.alu = ALU_AND; end
      OP_ORI:  begin ctrl.reg_we = 1'b1; ctrl.ext = EXT_Z16; ctrl.alu = ALU_OR;  end
      OP_XORI: begin ctrl.reg_we = 1'b1; ctrl.ext = EXT_Z16; ctrl.alu = ALU_XOR; end
      OP_HI:   begin ctrl.reg_we = 1'b1; ctrl.ext = EXT_HI16; ctrl.alu = ALU_PASSB; end
      OP_LW:   begin ctrl.reg_we = 1'b1; ctrl.wb = WB_MEM; end
      OP_SW:   ctrl.mem_we = 1'b1;
      OP_BEQZ: ctrl.pcs = PCS_BRZ;
      OP_J:    begin ctrl.ext = EXT_S26; ctrl.pcs = PCS_REL; end
      OP_JAL:  begin
        ctrl.ext = EXT_S26; ctrl.pcs = PCS_REL;
        ctrl.reg_we = 1'b1; ctrl.wb = WB_LINK; ctrl.dst = DST_LINK;
      end
      OP_JR:   ctrl.pcs = PCS_IND;
      OP_JALR: begin
        ctrl.pcs = PCS_IND; ctrl.reg_we = 1'b1; ctrl.wb = WB_LINK; ctrl.dst = DST_LINK;
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/hwc_regfile.sv
module hwc_regfile
  import hwc_pkg::*;
(
  input  logic            clk,
  input  logic [RIDX-1:0] ra_a,
  input  logic [RIDX-1:0] ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  assign rd_a = (ra_a == '0) ? '0 : mem[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : mem[ra_b];
endmodule

// File: rtl/hwc_alu.sv
module hwc_alu
  import hwc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/hwc_core.sv
module hwc_core
  import hwc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, imm_val, b_opnd, alu_y, rf_a, rf_b, wb_data;
  logic [RIDX-1:0] rs1, rs2, rs3, wb_addr;
  ctrl_t           ctrl;
  logic            op_known, rf_we, br_taken;

  assign rs1 = imem_data[25:21];
  assign rs2 = imem_data[20:16];
  assign rs3 = imem_data[15:11];

  hwc_decode u_dec (.opcode(imem_data[31:26]), .func(imem_data[5:0]), .ctrl(ctrl), .known(op_known));

  hwc_regfile u_rf (
    .clk(clk), .ra_a(rs1), .ra_b(rs2), .rd_a(rf_a), .rd_b(rf_b),
    .we(rf_we), .wa(wb_addr), .wd(wb_data)
  );

  assign imm_val = ext_imm(imem_data[IMM_L-1:0], ctrl.ext);
  assign b_opnd  = ctrl.b_imm ? imm_val : rf_b;

  hwc_alu u_alu (.op(ctrl.alu), .a(rf_a), .b(b_opnd), .y(alu_y));

  assign pc_plus4 = pc_q + XLEN'(PC_STEP);

  always_comb begin
    case (ctrl.wb)
      WB_MEM:  wb_data = dmem_rdata;
      WB_LINK: wb_data = pc_plus4;
      default: wb_data = alu_y;
    endcase
    case (ctrl.dst)
      DST_RF3:  wb_addr = rs3;
      DST_LINK: wb_addr = RIDX'(LINK_REG);
      default:  wb_addr = rs2;
    endcase
  end

  assign rf_we    = ctrl.reg_we & ~rst;
  assign br_taken = (ctrl.pcs == PCS_BRZ) && (rf_a == '0);

  always_comb begin
    case (ctrl.pcs)
      PCS_BRZ: pc_next = br_taken ? pc_plus4 + imm_val : pc_plus4;
      PCS_REL: pc_next = pc_plus4 + imm_val;
      PCS_IND: pc_next = rf_a;
      default: pc_next = pc_plus4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rf_b;
  assign dmem_we    = ctrl.mem_we & ~rst;

  // R1: no store strobe while reset is applied
  a_r1_no_store_in_reset: assert property (@(posedge clk) rst |-> !dmem_we);
  // R1: the first cycle out of reset fetches from address 0
  a_r1_pc_cleared: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> pc_q == '0);
  // R11: a sequential step lands on the old PC plus 4
  a_r11_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl.pcs == PCS_SEQ)) |-> pc_q == $past(pc_q) + XLEN'(PC_STEP));
  // R6: a taken branch lands on PC+4 plus the offset
  a_r6_branch_target: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_taken)) |-> pc_q == $past(pc_q) + XLEN'(PC_STEP) + $past(imm_val));
  // R7 and R8: a link write goes to R31 and carries the next sequential address
  a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
    (rf_we && ctrl.wb == WB_LINK) |-> (wb_addr == RIDX'(LINK_REG) && wb_data == imem_addr + XLEN'(PC_STEP)));
  // R10: an unknown opcode leaves registers and memory alone
  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (!rf_we && !dmem_we && ctrl.pcs == PCS_SEQ));
endmodule

// File: tb/hwc_core_bench.sv
module hwc_core_bench;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  int          nchk = 0, nfail = 0;
  bit          finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // data memory model: each word holds its own address xored with a tag
  assign dmem_rdata = dmem_addr ^ 32'hC0DE_0000;

  hwc_core u_hwc_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  function automatic logic [31:0] f_r(input int a, input int b, input int d, input logic [5:0] fn);
    return {6'h00, 5'(a), 5'(b), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] f_i(input logic [5:0] op, input int a, input int d, input logic [15:0] im);
    return {op, 5'(a), 5'(d), im};
  endfunction
  function automatic logic [31:0] f_j(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] pc;
    logic        we;
    logic        ld;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t V [NV] = '{
    '{f_i(6'h08, 0, 1, 16'h0005),  32'h000, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3},
    '{f_i(6'h08, 0, 2, 16'hFFFD),  32'h004, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3},
    '{f_r(1, 2, 3, 6'h20),         32'h008, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2},
    '{f_i(6'h2B, 0, 3, 16'h0010),  32'h00C, 1'b1, 1'b0, 32'h10, 32'h2, 4'd2},
    '{f_r(2, 1, 4, 6'h22),         32'h010, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2},
    '{f_i(6'h2B, 1, 4, 16'hFFFF),  32'h014, 1'b1, 1'b0, 32'h4, 32'hFFFF_FFF8, 4'd5},
    '{f_i(6'h09, 0, 5, 16'hFFFD),  32'h018, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3},
    '{f_i(6'h2B, 0, 5, 16'h0020),  32'h01C, 1'b1, 1'b0, 32'h20, 32'h0000_FFFD, 4'd3},
    '{f_i(6'h0F, 0, 6, 16'h1234),  32'h020, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3},
    '{f_i(6'h0D, 6, 6, 16'h8001),  32'h024, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3},
    '{f_i(6'h2B, 0, 6, 16'h0024),  32'h028, 1'b1, 1'b0, 32'h24, 32'h1234_8001, 4'd3},
    '{f_r(6, 5, 7, 6'h24),         32'h02C, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2},
    '{f_r(2, 1, 8, 6'h2A),         32'h030, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2},
    '{f_i(6'h2B, 8, 7, 16'h0007),  32'h034, 1'b1, 1'b0, 32'h8, 32'h0000_8001, 4'd2},
    '{f_i(6'h08, 0, 0, 16'h0055),  32'h038, 1'b0, 1'b0, 32'h0, 32'h0, 4'd9},
    '{f_i(6'h2B, 0, 0, 16'h0000),  32'h03C, 1'b1, 1'b0, 32'h0, 32'h0, 4'd9},
    '{f_i(6'h23, 0, 9, 16'h0040),  32'h040, 1'b0, 1'b1, 32'h40, 32'h0, 4'd4},
    '{f_i(6'h2B, 0, 9, 16'h0044),  32'h044, 1'b1, 1'b0, 32'h44, 32'hC0DE_0040, 4'd4},
    '{f_i(6'h04, 8, 0, 16'h0100),  32'h048, 1'b0, 1'b0, 32'h0, 32'h0, 4'd6},
    '{f_i(6'h04, 0, 0, 16'h0008),  32'h04C, 1'b0, 1'b0, 32'h0, 32'h0, 4'd6},
    '{f_j(6'h03, 26'h10),          32'h058, 1'b0, 1'b0, 32'h0, 32'h0, 4'd6},
    '{f_i(6'h2B, 0, 31, 16'h0048), 32'h06C, 1'b1, 1'b0, 32'h48, 32'h5C, 4'd7},
    '{f_j(6'h02, 26'h3FF_FFC0),    32'h070, 1'b0, 1'b0, 32'h0, 32'h0, 4'd7},
    '{f_i(6'h08, 0, 10, 16'h0100), 32'h034, 1'b0, 1'b0, 32'h0, 32'h0, 4'd7},
    '{f_i(6'h13, 10, 0, 16'h0000), 32'h038, 1'b0, 1'b0, 32'h0, 32'h0, 4'd8},
    '{f_i(6'h2B, 0, 31, 16'h004C), 32'h100, 1'b1, 1'b0, 32'h4C, 32'h3C, 4'd8},
    '{f_i(6'h08, 0, 11, 16'h0200), 32'h104, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3},
    '{f_i(6'h12, 11, 0, 16'h0000), 32'h108, 1'b0, 1'b0, 32'h0, 32'h0, 4'd8},
    '{f_i(6'h2B, 0, 31, 16'h0050), 32'h200, 1'b1, 1'b0, 32'h50, 32'h3C, 4'd8},
    '{f_i(6'h3F, 1, 31, 16'h0000), 32'h204, 1'b0, 1'b0, 32'h0, 32'h0, 4'd10},
    '{f_i(6'h2B, 0, 31, 16'h0054), 32'h208, 1'b1, 1'b0, 32'h54, 32'h3C, 4'd10},
    '{f_r(1, 8, 12, 6'h04),        32'h20C, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2},
    '{f_r(4, 8, 13, 6'h06),        32'h210, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2},
    '{f_r(13, 12, 14, 6'h26),      32'h214, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2},
    '{f_i(6'h2B, 0, 14, 16'h0058), 32'h218, 1'b1, 1'b0, 32'h58, 32'h7FFF_FFF6, 4'd2},
    '{f_i(6'h0A, 2, 15, 16'hFFFE), 32'h21C, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3},
    '{f_i(6'h2B, 0, 15, 16'h005C), 32'h220, 1'b1, 1'b0, 32'h5C, 32'h1, 4'd3}
  };

  function automatic string tg(input logic [3:0] k);
    case (k)
      4'd1: return "R1";   4'd2: return "R2";  4'd3: return "R3";  4'd4: return "R4";
      4'd5: return "R5";   4'd6: return "R6";  4'd7: return "R7";  4'd8: return "R8";
      4'd9: return "R9";   4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      nfail++;
      $display("FAIL R11 watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset with a store on the instruction port
    imem_data = f_i(6'h2B, 0, 0, 16'h0004);
    @(negedge clk);
    chk("R1 PC under reset", imem_addr, 32'h0);
    chk("R1 store strobe under reset", {31'd0, dmem_we}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // trace: one instruction per cycle, fetch address checked every step
    for (int i = 0; i < NV; i++) begin
      imem_data = V[i].ins;
      #2;
      chk($sformatf("PC step %0d (%s R11)", i, tg(V[i].rq)), imem_addr, V[i].pc);
      chk($sformatf("R5 strobe step %0d (%s)", i, tg(V[i].rq)), {31'd0, dmem_we}, {31'd0, V[i].we});
      if (V[i].we || V[i].ld)
        chk($sformatf("address step %0d (%s)", i, tg(V[i].rq)), dmem_addr, V[i].addr);
      if (V[i].we)
        chk($sformatf("store data step %0d (%s)", i, tg(V[i].rq)), dmem_wdata, V[i].wd);
      @(negedge clk);
    end
    chk("PC after last step (R11)", imem_addr, 32'h224);

    // R1: reset in mid-run, store on the bus must not strobe
    rst = 1'b1;
    imem_data = f_i(6'h2B, 0, 0, 16'h0060);
    #2;
    chk("R1 store strobe with reset mid-run", {31'd0, dmem_we}, 32'h0);
    @(negedge clk);
    chk("R1 PC cleared mid-run", imem_addr, 32'h0);
    rst = 1'b0;
    imem_data = f_i(6'h08, 0, 1, 16'h0001);
    #2;
    chk("R1 PC held at 0 after release", imem_addr, 32'h0);
    @(negedge clk);
    chk("R11 sequential step after reset", imem_addr, 32'h4);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule